// File: doc/BRIEF.md
# SIMT Divergence Reconvergence Stack

This block follows the control flow of one warp: a group of N scalar threads that share one instruction stream. It holds the active thread mask, the PC to fetch and the reconvergence PC of the innermost open branch. Each retired instruction is reported with a `step` pulse. A retired branch brings a per-thread taken mask, a target PC, a fall-through PC and a reconvergence PC. The reconvergence PC is computed ahead of time as the branch's immediate postdominator. A `join_hit` flag tells the block that the next PC is the current reconvergence point.

When threads split, the taken subset runs first. The not-taken subset waits on a bounded stack, together with its PC, the pre-branch mask and the enclosing reconvergence PC. The first arrival at the reconvergence point exchanges the finished subset for the waiting one. The second arrival pops the entry and resumes the whole pre-branch group at the reconvergence PC. Nested splits unwind in last-in first-out order. A `stall` output marks each exchange or merge so that fetch can redirect.

Top module: `simt_reconv_stack`

## Requirements
- R1: After reset the active mask is all ones, the fetch PC equals the parameter `RESET_PC`, `stall` is 0 and `overflow` is 0.
- R2: A step with `is_br`=0 and `join_hit`=0 sets the fetch PC to `seq_pc` and keeps the mask. With `step`=0, mask and PC hold whatever the other inputs carry.
- R3: A branch is uniform when (taken AND active) equals the active mask, and the PC becomes `tgt_pc`. It is also uniform when (taken AND active) is zero, and the PC becomes `fall_pc`. Taken bits of inactive threads are ignored. A uniform branch leaves the mask and the stack unchanged.
- R4: Any other branch is divergent. The mask becomes (taken AND active) and the PC becomes `tgt_pc`. The not-taken subset is deferred with `fall_pc`, and `join_pc` becomes the current reconvergence PC.
- R5: The first `join_hit` step for an open branch exchanges subsets. The mask becomes the deferred subset and the PC becomes its saved fall-through PC. `stall` is 1 combinationally in that step's cycle.
- R6: The second `join_hit` step for the same branch pops it. The mask becomes the pre-branch mask and the PC becomes that branch's reconvergence PC. `stall` is 1 in that cycle.
- R7: Splits nest. An inner branch is exchanged and popped before the outer one, and popping it restores the outer branch's reconvergence PC for the next merge.
- R8: A divergent branch while `DEPTH` entries are held sets the sticky `overflow` output and changes neither the mask nor the PC. Only reset clears `overflow`.
- R9: A `join_hit` step with an empty stack acts as a sequential step (PC becomes `seq_pc`) with `stall` at 0.
- R10: When `join_hit` and `is_br` are both set in one step with a non-empty stack, the reconvergence action is taken and the branch is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | One instruction of the warp retires this cycle |
| is_br | input | 1 | The retiring instruction is a branch |
| join_hit | input | 1 | The next PC is the current reconvergence point |
| taken | input | N | Per-thread branch outcome, 1 = taken |
| tgt_pc | input | PCW | Branch target PC |
| fall_pc | input | PCW | Branch fall-through PC |
| join_pc | input | PCW | Reconvergence PC supplied with the branch |
| seq_pc | input | PCW | Next PC for a non-branch step |
| act_mask | output | N | Threads enabled for the fetched instruction |
| fetch_pc | output | PCW | PC to fetch |
| stall | output | 1 | An exchange or merge happens this cycle |
| overflow | output | 1 | Sticky: a split was lost for lack of stack space |

## Verification
The bench builds the block with N=4, PCW=8 and DEPTH=2. Four threads are enough for a mask to split twice, one thread of each inner split after a two-way outer split, so two nesting levels can be fully opened and unwound. A depth of two lets a three-level split reach the overflow case in a few steps. The table walks uniform branches of both polarities, a nested split with exchange and merge at each level, and a reuse of a freed slot. Directed steps then cover the empty-stack join, overflow with its stickiness, join-over-branch priority and idle hold.

// File: rtl/dvg_pkg.sv
package dvg_pkg;
  // One decoded action per retired step.
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_SEQ,
    OP_UNI_T,
    OP_UNI_F,
    OP_DIV,
    OP_OVF,
    OP_SWAP,
    OP_POP
  } dvg_op_e;
endpackage

// File: rtl/dvg_classify.sv
module dvg_classify
  import dvg_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         step,
  input  logic         is_br,
  input  logic         join_hit,
  input  logic [N-1:0] act,
  input  logic [N-1:0] taken,
  input  logic         stk_empty,
  input  logic         stk_full,
  input  logic         top_swapped,
  output dvg_op_e      op
);
  // Taken bits only count for threads that are running.
  function automatic logic [N-1:0] live_taken(input logic [N-1:0] a, input logic [N-1:0] t);
    return a & t;
  endfunction

  logic [N-1:0] tk;
  assign tk = live_taken(act, taken);

  always_comb begin
    op = OP_IDLE;
    if (step) begin
      if (join_hit && !stk_empty) op = top_swapped ? OP_POP : OP_SWAP;
      else if (join_hit)          op = OP_SEQ;
      else if (is_br) begin
        if (tk == act)            op = OP_UNI_T;
        else if (tk == '0)        op = OP_UNI_F;
        else if (stk_full)        op = OP_OVF;
        else                      op = OP_DIV;
      end else                    op = OP_SEQ;
    end
  end
endmodule

// File: rtl/dvg_stack.sv
module dvg_stack #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_word,
  input  logic         mark,
  input  logic         pop,
  output logic [W-1:0] top_word,
  output logic         empty,
  output logic         full
);
  // Bit 0 of a word is the "already exchanged" flag, set by mark.
  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CW-1:0] cnt;
  logic [W-1:0]  slots [DEPTH];
  logic [AW-1:0] top_idx;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                           q <= '0;
      else if (push && cnt == CW'(i))       q <= push_word;
      else if (mark && cnt == CW'(i + 1))   q[0] <= 1'b1;
    end
    assign slots[i] = q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (push && !full)     cnt <= cnt + 1'b1;
    else if (pop && !empty)     cnt <= cnt - 1'b1;
  end

  assign top_idx  = empty ? '0 : AW'(cnt - 1'b1);
  assign top_word = slots[top_idx];
  assign empty    = (cnt == '0);
  assign full     = (cnt == CW'(DEPTH));
endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
  import dvg_pkg::*;
#(
  parameter int              N        = 8,
  parameter int              PCW      = 16,
  parameter int              DEPTH    = 4,
  parameter logic [PCW-1:0]  RESET_PC = '0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           step,
  input  logic           is_br,
  input  logic           join_hit,
  input  logic [N-1:0]   taken,
  input  logic [PCW-1:0] tgt_pc,
  input  logic [PCW-1:0] fall_pc,
  input  logic [PCW-1:0] join_pc,
  input  logic [PCW-1:0] seq_pc,
  output logic [N-1:0]   act_mask,
  output logic [PCW-1:0] fetch_pc,
  output logic           stall,
  output logic           overflow
);
  // Entry layout, high to low: pre-branch mask, outer join PC,
  // deferred mask, deferred PC, exchanged flag.
  localparam int EW = 2 * N + 2 * PCW + 1;

  function automatic logic [EW-1:0] pack_entry(
    input logic [N-1:0] full_m, input logic [PCW-1:0] outer,
    input logic [N-1:0] wait_m, input logic [PCW-1:0] wait_pc);
    return {full_m, outer, wait_m, wait_pc, 1'b0};
  endfunction

  function automatic logic [N-1:0] ent_full(input logic [EW-1:0] e);
    return e[EW-1 -: N];
  endfunction
  function automatic logic [PCW-1:0] ent_outer(input logic [EW-1:0] e);
    return e[EW-N-1 -: PCW];
  endfunction
  function automatic logic [N-1:0] ent_wait(input logic [EW-1:0] e);
    return e[PCW + N -: N];
  endfunction
  function automatic logic [PCW-1:0] ent_wpc(input logic [EW-1:0] e);
    return e[PCW:1];
  endfunction

  logic [N-1:0]   act_q;
  logic [PCW-1:0] pc_q;
  logic [PCW-1:0] rpc_q;
  logic           ovf_q;

  logic [EW-1:0]  top_word;
  logic           stk_empty, stk_full;
  dvg_op_e        op;

  // Named events for the checker.
  logic ev_div, ev_swap, ev_pop, ev_uni, ev_ovf;
  assign ev_div  = (op == OP_DIV);
  assign ev_swap = (op == OP_SWAP);
  assign ev_pop  = (op == OP_POP);
  assign ev_uni  = (op == OP_UNI_T) || (op == OP_UNI_F);
  assign ev_ovf  = (op == OP_OVF);

  dvg_classify #(.N(N)) u_cls (
    .step        (step),
    .is_br       (is_br),
    .join_hit    (join_hit),
    .act         (act_q),
    .taken       (taken),
    .stk_empty   (stk_empty),
    .stk_full    (stk_full),
    .top_swapped (top_word[0]),
    .op          (op)
  );

  dvg_stack #(.W(EW), .DEPTH(DEPTH)) u_stk (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (ev_div),
    .push_word (pack_entry(act_q, rpc_q, act_q & ~taken, fall_pc)),
    .mark      (ev_swap),
    .pop       (ev_pop),
    .top_word  (top_word),
    .empty     (stk_empty),
    .full      (stk_full)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= '1;
      pc_q  <= RESET_PC;
      rpc_q <= RESET_PC;
      ovf_q <= 1'b0;
    end else begin
      unique case (op)
        OP_SEQ:   pc_q <= seq_pc;
        OP_UNI_T: pc_q <= tgt_pc;
        OP_UNI_F: pc_q <= fall_pc;
        OP_DIV: begin
          act_q <= act_q & taken;
          pc_q  <= tgt_pc;
          rpc_q <= join_pc;
        end
        OP_OVF:   ovf_q <= 1'b1;
        OP_SWAP: begin
          act_q <= ent_wait(top_word);
          pc_q  <= ent_wpc(top_word);
        end
        OP_POP: begin
          act_q <= ent_full(top_word);
          pc_q  <= rpc_q;
          rpc_q <= ent_outer(top_word);
        end
        default: ;
      endcase
    end
  end

  assign act_mask = act_q;
  assign fetch_pc = pc_q;
  assign stall    = ev_swap || ev_pop;
  assign overflow = ovf_q;
endmodule

// File: rtl/simt_reconv_chk.sv
module simt_reconv_chk #(
  parameter int N   = 8,
  parameter int PCW = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           step,
  input logic [N-1:0]   act_mask,
  input logic [PCW-1:0] fetch_pc,
  input logic           overflow,
  input logic           ev_div,
  input logic           ev_swap,
  input logic           ev_pop,
  input logic           ev_uni,
  input logic           ev_ovf
);
  // R2: no step, no change
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> ($stable(act_mask) && $stable(fetch_pc)));

  // R3: a uniform branch keeps the mask
  a_r3_uniform_mask: assert property (@(posedge clk) disable iff (!rst_n)
    ev_uni |=> $stable(act_mask));

  // R4: the running subset is a strict, non-empty part of the old mask
  a_r4_split_subset: assert property (@(posedge clk) disable iff (!rst_n)
    ev_div |=> ((act_mask & ~$past(act_mask)) == '0) && (act_mask != '0)
               && (act_mask != $past(act_mask)));

  // R5: the exchanged-in subset shares no thread with the finished one
  a_r5_swap_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    ev_swap |=> ((act_mask & $past(act_mask)) == '0) && (act_mask != '0));

  // R6: a merge widens the mask to a superset
  a_r6_merge_superset: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pop |=> ((act_mask & $past(act_mask)) == $past(act_mask)));

  // R8: a lost split freezes the state and raises the flag
  a_r8_ovf_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ovf |=> ($stable(act_mask) && $stable(fetch_pc) && overflow));

  // R8: the flag is sticky
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R4: never an empty warp
  a_r4_mask_live: assert property (@(posedge clk) disable iff (!rst_n)
    act_mask != '0);
endmodule

bind simt_reconv_stack simt_reconv_chk #(.N(N), .PCW(PCW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .step     (step),
  .act_mask (act_mask),
  .fetch_pc (fetch_pc),
  .overflow (overflow),
  .ev_div   (ev_div),
  .ev_swap  (ev_swap),
  .ev_pop   (ev_pop),
  .ev_uni   (ev_uni),
  .ev_ovf   (ev_ovf)
);

// File: tb/simt_reconv_stack_test.sv
module simt_reconv_stack_test;
  localparam int         N      = 4;
  localparam int         PCW    = 8;
  localparam int         DEPTH  = 2;
  localparam logic [7:0] RST_PC = 8'h10;
  localparam time        CLK_PERIOD = 10ns;

  typedef struct packed {
    logic       jn;
    logic       br;
    logic [3:0] tk;
    logic [7:0] tgt;
    logic [7:0] fall;
    logic [7:0] jpc;
    logic [7:0] seq;
    logic [3:0] emask;
    logic [7:0] epc;
    logic       estall;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,4'h0,8'h00,8'h00,8'h00,8'h11, 4'hF,8'h11,1'b0}, // R2 sequential
    '{1'b0,1'b1,4'hF,8'h20,8'h12,8'h00,8'h00, 4'hF,8'h20,1'b0}, // R3 all taken
    '{1'b0,1'b1,4'h0,8'h30,8'h21,8'h00,8'h00, 4'hF,8'h21,1'b0}, // R3 none taken
    '{1'b0,1'b1,4'h3,8'h40,8'h22,8'h50,8'h00, 4'h3,8'h40,1'b0}, // R4 outer split
    '{1'b0,1'b0,4'h0,8'h00,8'h00,8'h00,8'h41, 4'h3,8'h41,1'b0}, // R2 inside split
    '{1'b0,1'b1,4'h1,8'h60,8'h42,8'h48,8'h00, 4'h1,8'h60,1'b0}, // R7 inner split
    '{1'b0,1'b1,4'h2,8'h70,8'h61,8'h00,8'h00, 4'h1,8'h61,1'b0}, // R3 inactive taken ignored
    '{1'b1,1'b0,4'h0,8'h00,8'h00,8'h00,8'h00, 4'h2,8'h42,1'b1}, // R5 inner exchange
    '{1'b1,1'b0,4'h0,8'h00,8'h00,8'h00,8'h00, 4'h3,8'h48,1'b1}, // R6 inner merge
    '{1'b1,1'b0,4'h0,8'h00,8'h00,8'h00,8'h00, 4'hC,8'h22,1'b1}, // R7 outer exchange
    '{1'b0,1'b1,4'h4,8'h80,8'h23,8'h4A,8'h00, 4'h4,8'h80,1'b0}, // R4 split reusing slot
    '{1'b1,1'b0,4'h0,8'h00,8'h00,8'h00,8'h00, 4'h8,8'h23,1'b1}, // R5 exchange
    '{1'b1,1'b0,4'h0,8'h00,8'h00,8'h00,8'h00, 4'hC,8'h4A,1'b1}, // R6 merge
    '{1'b1,1'b0,4'h0,8'h00,8'h00,8'h00,8'h00, 4'hF,8'h50,1'b1}, // R7 outer merge restores join PC
    '{1'b1,1'b0,4'h0,8'h00,8'h00,8'h00,8'h51, 4'hF,8'h51,1'b0}  // R9 empty-stack join
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           step = 1'b0, is_br = 1'b0, join_hit = 1'b0;
  logic [N-1:0]   taken = '0;
  logic [PCW-1:0] tgt_pc = '0, fall_pc = '0, join_pc = '0, seq_pc = '0;
  logic [N-1:0]   act_mask;
  logic [PCW-1:0] fetch_pc;
  logic           stall, overflow;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  simt_reconv_stack #(.N(N), .PCW(PCW), .DEPTH(DEPTH), .RESET_PC(RST_PC)) uut (
    .clk(clk), .rst_n(rst_n), .step(step), .is_br(is_br), .join_hit(join_hit),
    .taken(taken), .tgt_pc(tgt_pc), .fall_pc(fall_pc), .join_pc(join_pc),
    .seq_pc(seq_pc), .act_mask(act_mask), .fetch_pc(fetch_pc),
    .stall(stall), .overflow(overflow)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // Drive at the falling edge, read stall before the rising edge,
  // read the registered state just after it.
  task automatic do_step(input logic s, input logic jn, input logic br, input logic [3:0] tk,
                         input logic [7:0] tg, input logic [7:0] fl, input logic [7:0] jp,
                         input logic [7:0] sq, output logic st);
    @(negedge clk);
    step = s; join_hit = jn; is_br = br; taken = tk;
    tgt_pc = tg; fall_pc = fl; join_pc = jp; seq_pc = sq;
    #1 st = stall;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; step = 1'b0;
    @(posedge clk); @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  initial begin
    logic st;
    do_reset();
    chk("R1 mask",     32'(act_mask), 32'hF);
    chk("R1 pc",       32'(fetch_pc), 32'(RST_PC));
    chk("R1 overflow", 32'(overflow), 32'h0);
    chk("R1 stall",    32'(stall),    32'h0);

    for (int i = 0; i < NV; i++) begin
      do_step(1'b1, VEC[i].jn, VEC[i].br, VEC[i].tk, VEC[i].tgt, VEC[i].fall,
              VEC[i].jpc, VEC[i].seq, st);
      if (st !== VEC[i].estall) begin
        n_fail++;
        $display("FAIL vector %0d stall (R5 R6 R9): got %0b expected %0b", i, st, VEC[i].estall);
      end
      n_chk++;
      if (act_mask !== VEC[i].emask || fetch_pc !== VEC[i].epc) begin
        n_fail++;
        $display("FAIL vector %0d mask/pc: got %0h/%0h expected %0h/%0h",
                 i, act_mask, fetch_pc, VEC[i].emask, VEC[i].epc);
      end
      n_chk++;
    end

    // Overflow: three nested splits with room for two (R8)
    do_reset();
    do_step(1'b1, 1'b0, 1'b1, 4'h7, 8'h20, 8'h30, 8'h40, 8'h00, st);
    chk("R4 first split mask", 32'(act_mask), 32'h7);
    do_step(1'b1, 1'b0, 1'b1, 4'h3, 8'h21, 8'h31, 8'h41, 8'h00, st);
    chk("R4 second split mask", 32'(act_mask), 32'h3);
    chk("R8 no overflow yet", 32'(overflow), 32'h0);
    do_step(1'b1, 1'b0, 1'b1, 4'h1, 8'h22, 8'h32, 8'h42, 8'h00, st);
    chk("R8 overflow set",    32'(overflow), 32'h1);
    chk("R8 mask unchanged",  32'(act_mask), 32'h3);
    chk("R8 pc unchanged",    32'(fetch_pc), 32'h21);
    do_step(1'b1, 1'b0, 1'b0, 4'h0, 8'h00, 8'h00, 8'h00, 8'h25, st);
    chk("R8 overflow sticky", 32'(overflow), 32'h1);
    chk("R2 pc after overflow", 32'(fetch_pc), 32'h25);

    // R10: join and divergent branch together -> exchange wins
    do_step(1'b1, 1'b1, 1'b1, 4'h1, 8'h99, 8'h98, 8'h97, 8'h00, st);
    chk("R10 stall",  32'(st),       32'h1);
    chk("R10 mask",   32'(act_mask), 32'h4);
    chk("R10 pc",     32'(fetch_pc), 32'h31);

    // R2: no step, inputs ignored
    do_step(1'b0, 1'b1, 1'b1, 4'hF, 8'h77, 8'h76, 8'h75, 8'h74, st);
    chk("R2 idle stall", 32'(st),       32'h0);
    chk("R2 idle mask",  32'(act_mask), 32'h4);
    chk("R2 idle pc",    32'(fetch_pc), 32'h31);

    // R1: reset clears the sticky flag
    do_reset();
    chk("R1 overflow cleared", 32'(overflow), 32'h0);
    chk("R1 mask again",       32'(act_mask), 32'hF);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule